// File: doc/BRIEF.md
# Inactivity-Driven Multi-Level Sleep Controller

This block decides the power state of a processor from two inputs: a level-sensitive busy flag and a wake request. While the core runs, it counts consecutive idle cycles. When the count reaches a programmable limit, it starts a shutdown phase. After the shutdown phase the core sleeps in the lightest low-power level. Each time the core stays asleep for a further programmable dwell, the controller moves it one level deeper. There are five levels, and the deepest one is held until a wake request arrives.

A wake request stops sleeping on demand. The controller then runs a wakeup phase. Its length is a base unit multiplied by the depth reached, so deeper levels take longer to leave. The outputs are a core clock enable, one power enable per non-retained island and a compact mode code. The island that holds cache and memory contents has no output here, because it is never switched off. The analog switches and any state save and restore sit outside this block.

Top module: `pwr_depth_ctl`

## Requirements
- R1: In the run state, `idle_limit_i` consecutive cycles with `busy_i` and `wake_i` both low start shutdown. The shutdown phase reports mode code 1 with `ready_o` low and the clock still enabled. A limit of 1 starts shutdown after a single idle cycle.
- R2: In the run state, a cycle with `busy_i` or `wake_i` high resets the idle count to zero, and the block stays in the run state.
- R3: Shutdown lasts `down_cycles_i` cycles. The block then sleeps at the lightest level with `core_clk_en_o` low.
- R4: After `dwell_limit_i` cycles asleep at one level, the block moves one level deeper and the mode code rises by one. At the deepest level (mode code 5) it stays put.
- R5: `core_clk_en_o` is low only while asleep. Island bit i is low only while asleep at a level whose index (0 to 4) is greater than i. So the lightest level only gates the clock, and the deepest level switches off all four islands.
- R6: A wake request while asleep enters the wakeup phase on the next edge. The clock and all islands come back on, and the mode code keeps the level being left.
- R7: A wake request during shutdown abandons the shutdown and enters wakeup with the latency of the lightest level.
- R8: Wakeup lasts `up_unit_i` × (level index + 1) cycles and then returns to the run state. Wake requests during wakeup have no effect on it.
- R9: The mode code is 0 and `ready_o` is high exactly in the run state. Otherwise the mode code is the level index plus 1.
- R10: Synchronous active-high reset returns the block to the run state with the idle count cleared and every enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Core activity in this cycle |
| wake_i | input | 1 | Wake request |
| idle_limit_i | input | IDLE_W | Idle cycles before shutdown (at least 1) |
| dwell_limit_i | input | DWELL_W | Cycles per sleep level before deepening (at least 1) |
| down_cycles_i | input | TRANS_W | Shutdown length in cycles (at least 1) |
| up_unit_i | input | TRANS_W | Wakeup cycles per depth step (at least 1) |
| core_clk_en_o | output | 1 | Core clock enable |
| island_en_o | output | N_LEVELS-1 | Power enables of the non-retained islands |
| mode_o | output | MODE_W | 0 in run, level index + 1 otherwise |
| ready_o | output | 1 | High only in the run state |

## Verification
The hardest case to reach is an abandoned shutdown. During shutdown the outputs look exactly like the first wakeup cycle: mode 1, clock on, all islands on. The stimulus therefore raises the wake request one cycle into shutdown. It then checks the cycle in which an uninterrupted shutdown would already have gated the clock, and the cycle after that, when the block must be back in run. The deepest level is reached only by holding the core idle through four dwell periods. From there, a wakeup with the wake request held high shows both the longest latency and that repeated requests have no effect on it.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    // Number of ordered low-power depths.
    localparam int LEVELS_DEF = 5;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_DOWN  = 2'd1,
        PS_SLEEP = 2'd2,
        PS_UP    = 2'd3
    } pstate_e;

    function automatic logic is_transit(input pstate_e s);
        return (s == PS_DOWN) || (s == PS_UP);
    endfunction

endpackage

// File: rtl/pdc_counter.sv
module pdc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0] cnt;

    // Flags the cycle that would complete limit_i increments.
    assign hit_o = inc_i && ((cnt + W'(1)) == limit_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt <= '0;
        else if (inc_i)
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/pdc_gate_map.sv
module pdc_gate_map
    import pdc_pkg::*;
#(
    parameter int N_LEVELS = LEVELS_DEF,
    localparam int LVL_W  = $clog2(N_LEVELS),
    localparam int MODE_W = $clog2(N_LEVELS + 1)
) (
    input  pstate_e               st_i,
    input  logic [LVL_W-1:0]      lvl_i,
    output logic                  clk_en_o,
    output logic [N_LEVELS-2:0]   isl_en_o,
    output logic [MODE_W-1:0]     mode_o,
    output logic                  ready_o
);
    logic asleep;
    assign asleep   = (st_i == PS_SLEEP);
    assign clk_en_o = !asleep;
    assign ready_o  = (st_i == PS_RUN);
    assign mode_o   = ready_o ? '0 : MODE_W'(lvl_i) + MODE_W'(1);

    // Island k loses power once the depth index exceeds k.
    for (genvar k = 0; k < N_LEVELS - 1; k++) begin : g_isl
        assign isl_en_o[k] = !(asleep && (lvl_i > LVL_W'(k)));
    end
endmodule

// File: rtl/pwr_depth_ctl.sv
module pwr_depth_ctl
    import pdc_pkg::*;
#(
    parameter int N_LEVELS = LEVELS_DEF,
    parameter int IDLE_W   = 16,
    parameter int DWELL_W  = 16,
    parameter int TRANS_W  = 8,
    localparam int LVL_W   = $clog2(N_LEVELS),
    localparam int MODE_W  = $clog2(N_LEVELS + 1),
    localparam int TL_W    = TRANS_W + LVL_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 busy_i,
    input  logic                 wake_i,
    input  logic [IDLE_W-1:0]    idle_limit_i,
    input  logic [DWELL_W-1:0]   dwell_limit_i,
    input  logic [TRANS_W-1:0]   down_cycles_i,
    input  logic [TRANS_W-1:0]   up_unit_i,
    output logic                 core_clk_en_o,
    output logic [N_LEVELS-2:0]  island_en_o,
    output logic [MODE_W-1:0]    mode_o,
    output logic                 ready_o
);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(N_LEVELS - 1);

    pstate_e          st, st_n;
    logic [LVL_W-1:0] lvl, lvl_n;
    logic             idle_hit, dwell_hit, tr_hit;
    logic             active;
    logic [TL_W-1:0]  up_len, tr_limit;

    assign active = busy_i || wake_i;

    // Wakeup latency scales with the depth being left.
    assign up_len   = TL_W'(up_unit_i) * (TL_W'(lvl) + TL_W'(1));
    assign tr_limit = (st == PS_UP) ? up_len : TL_W'(down_cycles_i);

    pdc_counter #(.W(IDLE_W)) u_idle (
        .clk(clk), .rst(rst),
        .clr_i((st != PS_RUN) || active),
        .inc_i((st == PS_RUN) && !active),
        .limit_i(idle_limit_i),
        .hit_o(idle_hit)
    );

    pdc_counter #(.W(DWELL_W)) u_dwell (
        .clk(clk), .rst(rst),
        .clr_i((st != PS_SLEEP) || dwell_hit),
        .inc_i(st == PS_SLEEP),
        .limit_i(dwell_limit_i),
        .hit_o(dwell_hit)
    );

    pdc_counter #(.W(TL_W)) u_trans (
        .clk(clk), .rst(rst),
        .clr_i(st_n != st),
        .inc_i(is_transit(st)),
        .limit_i(tr_limit),
        .hit_o(tr_hit)
    );

    always_comb begin
        st_n  = st;
        lvl_n = lvl;
        unique case (st)
            PS_RUN: begin
                if (idle_hit) begin
                    st_n  = PS_DOWN;
                    lvl_n = '0;
                end
            end
            PS_DOWN: begin
                if (wake_i)      st_n = PS_UP;
                else if (tr_hit) st_n = PS_SLEEP;
            end
            PS_SLEEP: begin
                if (wake_i)
                    st_n = PS_UP;
                else if (dwell_hit && (lvl != LVL_MAX))
                    lvl_n = lvl + LVL_W'(1);
            end
            PS_UP: begin
                if (tr_hit) st_n = PS_RUN;
            end
            default: st_n = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PS_RUN;
            lvl <= '0;
        end else begin
            st  <= st_n;
            lvl <= lvl_n;
        end
    end

    pdc_gate_map #(.N_LEVELS(N_LEVELS)) u_map (
        .st_i(st),
        .lvl_i(lvl),
        .clk_en_o(core_clk_en_o),
        .isl_en_o(island_en_o),
        .mode_o(mode_o),
        .ready_o(ready_o)
    );
endmodule

// File: rtl/pwr_depth_ctl_chk.sv
module pwr_depth_ctl_chk #(
    parameter int N_ISL  = 4,
    parameter int MODE_W = 3,
    parameter int MODE_TOP = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_i,
    input logic              wake_i,
    input logic              core_clk_en_o,
    input logic [N_ISL-1:0]  island_en_o,
    input logic [MODE_W-1:0] mode_o,
    input logic              ready_o
);
    // R2: activity in run keeps the core running
    a_r2_busy_holds_run: assert property (@(posedge clk) disable iff (rst)
        (ready_o && busy_i) |=> ready_o);

    // R5: a gated clock never coexists with run
    a_r5_gate_only_asleep: assert property (@(posedge clk) disable iff (rst)
        !core_clk_en_o |-> (!ready_o && mode_o != '0));

    // R5: the lightest level keeps every island powered
    a_r5_lpm0_clock_only: assert property (@(posedge clk) disable iff (rst)
        (!core_clk_en_o && mode_o == MODE_W'(1)) |-> (&island_en_o));

    // R4: the deepest level holds without a wake request
    a_r4_deepest_holds: assert property (@(posedge clk) disable iff (rst)
        (!core_clk_en_o && !wake_i && mode_o == MODE_W'(MODE_TOP))
        |=> (!core_clk_en_o && mode_o == MODE_W'(MODE_TOP)));

    // R4: depth rises by at most one step per cycle
    a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
        (mode_o != '0) |=> (mode_o == '0 || int'(mode_o) <= int'($past(mode_o)) + 1));

    // R6: a wake request while asleep restores the clock next cycle
    a_r6_wake_restores_clock: assert property (@(posedge clk) disable iff (rst)
        (!core_clk_en_o && wake_i) |=> (core_clk_en_o && (&island_en_o)));
endmodule

bind pwr_depth_ctl pwr_depth_ctl_chk #(
    .N_ISL(N_LEVELS - 1),
    .MODE_W(MODE_W),
    .MODE_TOP(N_LEVELS)
) u_chk (
    .clk(clk),
    .rst(rst),
    .busy_i(busy_i),
    .wake_i(wake_i),
    .core_clk_en_o(core_clk_en_o),
    .island_en_o(island_en_o),
    .mode_o(mode_o),
    .ready_o(ready_o)
);

// File: tb/pwr_depth_ctl_tb.sv
`timescale 1ns/1ps
module pwr_depth_ctl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        busy = 1'b0;
    logic        wake = 1'b0;
    logic [15:0] idle_lim = 16'd3;
    logic [15:0] dwell_lim = 16'd4;
    logic [7:0]  down_len = 8'd2;
    logic [7:0]  up_unit = 8'd2;
    logic        clk_en, ready;
    logic [3:0]  isl;
    logic [2:0]  mode;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pwr_depth_ctl u_dut (
        .clk(clk), .rst(rst), .busy_i(busy), .wake_i(wake),
        .idle_limit_i(idle_lim), .dwell_limit_i(dwell_lim),
        .down_cycles_i(down_len), .up_unit_i(up_unit),
        .core_clk_en_o(clk_en), .island_en_o(isl),
        .mode_o(mode), .ready_o(ready)
    );

    // {busy, wake, cycles, mode, ready, clk_en, islands, requirement}
    localparam int NV = 25;
    localparam logic [22:0] VEC [NV] = '{
        {1'b0,1'b0,8'd2, 3'd0,1'b1,1'b1,4'hF,4'd1},  // R1 still running
        {1'b0,1'b0,8'd1, 3'd1,1'b0,1'b1,4'hF,4'd1},  // R1 shutdown starts
        {1'b0,1'b0,8'd1, 3'd1,1'b0,1'b1,4'hF,4'd3},  // R3 still shutting down
        {1'b0,1'b0,8'd1, 3'd1,1'b0,1'b0,4'hF,4'd3},  // R3 asleep at lightest
        {1'b0,1'b0,8'd3, 3'd1,1'b0,1'b0,4'hF,4'd5},  // R5 clock-only gating
        {1'b0,1'b0,8'd1, 3'd2,1'b0,1'b0,4'hE,4'd4},  // R4 level 1
        {1'b0,1'b0,8'd4, 3'd3,1'b0,1'b0,4'hC,4'd4},  // R4 level 2
        {1'b0,1'b0,8'd4, 3'd4,1'b0,1'b0,4'h8,4'd4},  // R4 level 3
        {1'b0,1'b0,8'd4, 3'd5,1'b0,1'b0,4'h0,4'd4},  // R4 deepest
        {1'b0,1'b0,8'd12,3'd5,1'b0,1'b0,4'h0,4'd4},  // R4 deepest holds
        {1'b0,1'b1,8'd1, 3'd5,1'b0,1'b1,4'hF,4'd6},  // R6 wakeup begins
        {1'b0,1'b1,8'd8, 3'd5,1'b0,1'b1,4'hF,4'd8},  // R8 wake held, ignored
        {1'b0,1'b0,8'd1, 3'd5,1'b0,1'b1,4'hF,4'd8},  // R8 last wakeup cycle
        {1'b0,1'b0,8'd1, 3'd0,1'b1,1'b1,4'hF,4'd8},  // R8 back to run after 10
        {1'b0,1'b0,8'd2, 3'd0,1'b1,1'b1,4'hF,4'd2},  // R2 idle 2
        {1'b1,1'b0,8'd1, 3'd0,1'b1,1'b1,4'hF,4'd2},  // R2 busy clears
        {1'b0,1'b0,8'd2, 3'd0,1'b1,1'b1,4'hF,4'd2},  // R2 restarted count
        {1'b0,1'b0,8'd1, 3'd1,1'b0,1'b1,4'hF,4'd2},  // R2 shutdown after 3 new
        {1'b0,1'b1,8'd1, 3'd1,1'b0,1'b1,4'hF,4'd7},  // R7 abort request
        {1'b0,1'b0,8'd1, 3'd1,1'b0,1'b1,4'hF,4'd7},  // R7 clock not gated
        {1'b0,1'b0,8'd1, 3'd0,1'b1,1'b1,4'hF,4'd7},  // R7 run after short wakeup
        {1'b0,1'b0,8'd5, 3'd1,1'b0,1'b0,4'hF,4'd3},  // R3 asleep again
        {1'b0,1'b1,8'd1, 3'd1,1'b0,1'b1,4'hF,4'd6},  // R6 shallow wakeup
        {1'b0,1'b0,8'd1, 3'd1,1'b0,1'b1,4'hF,4'd8},  // R8 one cycle left
        {1'b0,1'b0,8'd1, 3'd0,1'b1,1'b1,4'hF,4'd9}   // R9 run after 2
    };

    task automatic check(input int req, input logic [2:0] em, input logic er,
                         input logic ec, input logic [3:0] ei);
        total++;
        if (mode !== em || ready !== er || clk_en !== ec || isl !== ei) begin
            bad++;
            $display("FAIL R%0d: mode=%0d ready=%0b clk_en=%0b isl=%h, expected mode=%0d ready=%0b clk_en=%0b isl=%h",
                     req, mode, ready, clk_en, isl, em, er, ec, ei);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(10, 3'd0, 1'b1, 1'b1, 4'hF);  // R10 reset state

        for (int v = 0; v < NV; v++) begin
            busy = VEC[v][22];
            wake = VEC[v][21];
            repeat (int'(VEC[v][20:13])) @(posedge clk);
            @(negedge clk);
            check(int'(VEC[v][3:0]), VEC[v][12:10], VEC[v][9], VEC[v][8], VEC[v][7:4]);
        end
        busy = 1'b0;
        wake = 1'b0;

        // R5: level 1 gates island 0 only
        repeat (9) @(posedge clk);
        @(negedge clk);
        check(5, 3'd2, 1'b0, 1'b0, 4'hE);

        // R10: reset while asleep
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(10, 3'd0, 1'b1, 1'b1, 4'hF);

        // R1: limit of one idle cycle
        idle_lim = 16'd1;
        @(posedge clk);
        @(negedge clk);
        check(1, 3'd1, 1'b0, 1'b1, 4'hF);

        // R9: mode code stays 1 with ready low while shutting down
        check(9, 3'd1, 1'b0, 1'b1, 4'hF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule